// File: doc/BRIEF.md
# Two-Cycle Parallel Bus Master

This block sits on the host side of a narrow external parallel bus and turns internal word requests into bus cycles. The external bus carries a 12-bit halfword address, a 16-bit data path, separate read and write strobes, and a bus clock that the block forwards on its own pin. The peripheral samples the bus on that clock. The bus clock is derived from the system clock by a programmable divider.

A requester presents an address, a direction, a size (16 or 32 bit) and write data, and holds its request line high until it sees a one-cycle acknowledge. A 32-bit access is split into two halfword transfers: the low half goes to the given address and the high half to the next one. Every read, and every write when the two-cycle write option is set, is made of an address phase followed by a separate data phase. The strobe is high only in the address phase, so each halfword costs two bus clocks even inside a 32-bit access. With the option cleared, a write halfword takes a single bus clock.

The data pins are presented as a split output, output-enable and input triple, which a pad cell turns into a bidirectional pin. The block drives data only during a write's data phase.

Top module: `pbus_master`

## Requirements
- R1: While reset is high and on the first cycle after it, both strobes are low, the data output enable is low, the bus clock is low and the acknowledge is low.
- R2: The bus clock has a period of 2*max(cfg_div,1) system clocks and is high for max(cfg_div,1) of them; cfg_div values 0 and 1 both give half the system clock.
- R3: A 16-bit read spans two bus clocks with the same address on both. The read strobe is high in the first and low in the second. The block samples bus_dq_i at the end of the second, places it in rdata[15:0] and sets rdata[31:16] to zero.
- R4: A 32-bit access makes two halfword transfers back to back with no idle bus clock between them: address A carrying bits [15:0] first, then address A+1 modulo 4096 carrying bits [31:16]. A 32-bit read pulses the read strobe twice in four bus clocks.
- R5: With cfg_wr2 set, a write halfword has two bus clocks. In the first the write strobe is high and data is not driven. In the second the write strobe is low and the halfword is driven, on the same address.
- R6: With cfg_wr2 clear, a write halfword has one bus clock with the write strobe high and the address and data driven together.
- R7: bus_dq_oe is high only in a write's data phase and is low in every read and idle bus clock.
- R8: The acknowledge is a single system-clock pulse at the end of the last halfword, with rdata valid in that cycle. A request is accepted only in an idle bus clock, so a request held high across its acknowledge begins again only after one idle bus clock. Between bus clock rising edges no bus output changes.
- R9: The read and write strobes are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Bus clock half period in system clocks (0 treated as 1) |
| cfg_wr2 | input | 1 | 1: writes use separate address and data phases |
| req | input | 1 | Request, held until acknowledge |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_addr | input | ADDR_W | Halfword address of the access |
| req_wdata | input | 2*DATA_W | Write data, low half sent first |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 2*DATA_W | Read data, valid with ack |
| bus_clk | output | 1 | Forwarded bus clock |
| bus_addr | output | ADDR_W | External address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_dq_o | output | DATA_W | Data driven toward the pin |
| bus_dq_oe | output | 1 | Data pin output enable |
| bus_dq_i | input | DATA_W | Data sampled from the pin |

## Verification
The bench builds the block with its defaults: a 12-bit address, 16-bit data and an 8-bit divider field. The 12-bit address puts the wrap from 0xFFF to 0x000 inside a 32-bit access within reach. The 8-bit field lets the bench run the bus clock at divider settings 0, 1 and 3, measuring period and high time and repeating a read at the slow rate. The modelled peripheral returns a fixed marker value whenever a strobe or the output enable is high, so a read sampled in the wrong phase shows up as a wrong value.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  // Phase of the sequencer within one halfword transfer
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // no transfer, bus quiet
    PH_ADDR = 2'd1,  // strobe high, address valid
    PH_DATA = 2'd2,  // strobe low, data phase
    PH_ONE  = 2'd3   // single-clock write: strobe, address and data together
  } phase_t;

  // Half period of the bus clock in system clocks for a divider setting
  function automatic logic [31:0] half_len(input logic [31:0] d);
    return (d == 32'd0) ? 32'd1 : d;
  endfunction

endpackage

// File: rtl/pbus_clkdiv.sv
module pbus_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             bus_clk,
  output logic             rise_tick
);
  import pbus_pkg::*;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  always_comb begin
    lim  = DIV_W'(half_len(32'(div_cfg)) - 32'd1);
    // >= keeps the counter bounded if the divider is lowered on the fly
    wrap = (cnt >= lim);
  end

  // Event brought out for the sequencer: bus clock rises at this edge
  assign rise_tick = wrap && !bus_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      bus_clk <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      bus_clk <= ~bus_clk;
    end else begin
      cnt     <= cnt + DIV_W'(1);
    end
  end

  // R2: the rise event is followed by a high bus clock that was low before
  p_rise_r2: assert property (@(posedge clk) disable iff (rst)
    rise_tick |=> $rose(bus_clk));

  // R2: the bus clock only moves when the half period has elapsed
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(bus_clk));

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            cfg_wr2,
  input  logic            req,
  input  logic            req_wr,
  input  logic            req_wide,
  input  logic [AW-1:0]   req_addr,
  input  logic [2*DW-1:0] req_wdata,
  output logic            ack,
  output logic [2*DW-1:0] rdata,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic [DW-1:0]   dq_o,
  output logic            dq_oe,
  input  logic [DW-1:0]   dq_i
);
  import pbus_pkg::*;

  localparam int WW = 2 * DW;

  phase_t          ph;
  logic            hi;      // 0: low halfword, 1: high halfword
  logic            wr_l;
  logic            wide_l;
  logic [AW-1:0]   base;
  logic [WW-1:0]   wd;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [DW-1:0] pick_half(input logic [WW-1:0] w, input logic h);
    return h ? w[WW-1:DW] : w[DW-1:0];
  endfunction

  // Named events for the checks below
  logic last_half;
  assign last_half = !wide_l || hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      hi       <= 1'b0;
      wr_l     <= 1'b0;
      wide_l   <= 1'b0;
      base     <= '0;
      wd       <= '0;
      bus_addr <= '0;
      bus_rd   <= 1'b0;
      bus_wr   <= 1'b0;
      dq_o     <= '0;
      dq_oe    <= 1'b0;
      ack      <= 1'b0;
      rdata    <= '0;
    end else begin
      ack <= 1'b0;
      if (tick) begin
        case (ph)
          PH_IDLE: begin
            if (req) begin
              base     <= req_addr;
              wd       <= req_wdata;
              wr_l     <= req_wr;
              wide_l   <= req_wide;
              hi       <= 1'b0;
              bus_addr <= req_addr;
              if (req_wr) begin
                bus_wr <= 1'b1;
                if (cfg_wr2) begin
                  ph <= PH_ADDR;
                end else begin
                  ph    <= PH_ONE;
                  dq_oe <= 1'b1;
                  dq_o  <= req_wdata[DW-1:0];
                end
              end else begin
                bus_rd <= 1'b1;
                rdata  <= '0;
                ph     <= PH_ADDR;
              end
            end
          end
          PH_ADDR: begin
            bus_rd <= 1'b0;
            bus_wr <= 1'b0;
            if (wr_l) begin
              dq_oe <= 1'b1;
              dq_o  <= pick_half(wd, hi);
            end
            ph <= PH_DATA;
          end
          default: begin  // PH_DATA or PH_ONE: halfword ends here
            if (!wr_l) begin
              if (hi) rdata[WW-1:DW] <= dq_i;
              else    rdata[DW-1:0]  <= dq_i;
            end
            if (!last_half) begin
              hi       <= 1'b1;
              bus_addr <= step_addr(base);
              if (wr_l) begin
                bus_wr <= 1'b1;
                if (ph == PH_ONE) begin
                  dq_oe <= 1'b1;
                  dq_o  <= pick_half(wd, 1'b1);
                end else begin
                  dq_oe <= 1'b0;
                  ph    <= PH_ADDR;
                end
              end else begin
                bus_rd <= 1'b1;
                ph     <= PH_ADDR;
              end
            end else begin
              ph     <= PH_IDLE;
              ack    <= 1'b1;
              bus_rd <= 1'b0;
              bus_wr <= 1'b0;
              dq_oe  <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  // R3: a read strobe lasts exactly one bus clock
  p_rd_one_clock_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && bus_rd) |=> !bus_rd);

  // R5: a two-phase write address clock is followed by data with strobe low
  p_wr_split_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && bus_wr && !dq_oe) |=> (dq_oe && !bus_wr));

  // R7: data is never driven while idle or together with a read strobe
  p_oe_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE || bus_rd) |-> !dq_oe);

  // R8: acknowledge is a single-cycle pulse and never follows a read address phase
  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  p_ack_late_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && bus_rd) |=> !ack);

  // R8: bus outputs move only on a bus clock rising edge
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(bus_addr) && $stable(bus_rd) && $stable(bus_wr) && $stable(dq_oe)));

endmodule

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                cfg_wr2,
  input  logic                req,
  input  logic                req_wr,
  input  logic                req_wide,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*DATA_W-1:0] req_wdata,
  output logic                ack,
  output logic [2*DATA_W-1:0] rdata,
  output logic                bus_clk,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_rd,
  output logic                bus_wr,
  output logic [DATA_W-1:0]   bus_dq_o,
  output logic                bus_dq_oe,
  input  logic [DATA_W-1:0]   bus_dq_i
);

  logic rise_tick;

  pbus_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .div_cfg   (cfg_div),
    .bus_clk   (bus_clk),
    .rise_tick (rise_tick)
  );

  pbus_seq #(.AW(ADDR_W), .DW(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (rise_tick),
    .cfg_wr2   (cfg_wr2),
    .req       (req),
    .req_wr    (req_wr),
    .req_wide  (req_wide),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ack       (ack),
    .rdata     (rdata),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .dq_o      (bus_dq_o),
    .dq_oe     (bus_dq_oe),
    .dq_i      (bus_dq_i)
  );

  // R9: strobes are mutually exclusive
  p_no_both_r9: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R1: first cycle after reset is quiet
  p_reset_quiet_r1: assert property (@(posedge clk)
    $fell(rst) |-> (!bus_rd && !bus_wr && !bus_dq_oe && !ack));

endmodule

// File: tb/pbus_master_test.sv
module pbus_master_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cfg_div = 8'd1;
  logic        cfg_wr2 = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic        req_wide = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic        bus_clk;
  logic [11:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_dq_o;
  logic        bus_dq_oe;
  logic [15:0] bus_dq_i;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pbus_master uut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_wr2(cfg_wr2),
    .req(req), .req_wr(req_wr), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .bus_clk(bus_clk),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_dq_o(bus_dq_o), .bus_dq_oe(bus_dq_oe), .bus_dq_i(bus_dq_i)
  );

  // Peripheral model: value depends on address; a marker while strobes or OE are up
  function automatic logic [15:0] pv(input logic [11:0] a);
    return {a[3:0], a} ^ 16'h3C00;
  endfunction
  assign bus_dq_i = (bus_rd || bus_wr || bus_dq_oe) ? 16'hDEAD : pv(bus_addr);

  function automatic int per_of(input logic [7:0] d);
    return 2 * ((d == 8'd0) ? 1 : int'(d));
  endfunction

  // Bus cycle log: {rd, wr, oe, addr[11:0], dq[15:0]} taken after each bus clock rise
  logic [30:0] lg [1024];
  int          lg_n = 0;
  logic        pbc = 1'b0;
  int          both_seen = 0;

  always @(negedge clk) begin
    if (bus_clk && !pbc) begin
      lg[lg_n & 1023] = {bus_rd, bus_wr, bus_dq_oe, bus_addr, bus_dq_o};
      lg_n = lg_n + 1;
    end
    pbc = bus_clk;
    if (!rst && bus_rd && bus_wr) both_seen = both_seen + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_ent(input int i, input logic rd, input logic wr, input logic oe,
                         input logic [11:0] a, input logic [15:0] dq, input string tag);
    logic [30:0] act, exp, msk;
    act = lg[i & 1023];
    exp = {rd, wr, oe, a, dq};
    msk = oe ? {31{1'b1}} : {{15{1'b1}}, 16'h0};
    chk(((act ^ exp) & msk) == 31'd0, tag, 64'(act), 64'(exp));
  endtask

  task automatic chk_idle(input int i, input string tag);
    logic [30:0] act;
    act = lg[i & 1023];
    chk(act[30:28] == 3'b000, tag, 64'(act[30:28]), 64'd0);
  endtask

  int          t0;
  logic [31:0] got;

  // Issue one request, wait for acknowledge, leave the bus idle a while
  task automatic access(input logic w, input logic wide, input logic [11:0] a,
                        input logic [31:0] d, input bit hold);
    int st;
    int guard;
    bit seen;
    @(negedge clk);
    st = lg_n;
    req = 1'b1; req_wr = w; req_wide = wide; req_addr = a; req_wdata = d;
    guard = 0; seen = 1'b0;
    while (!seen && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (ack) begin seen = 1'b1; got = rdata; end
    end
    if (!hold) req = 1'b0;
    chk(seen, "R8 acknowledge arrives", 64'(seen), 64'd1);
    @(negedge clk);
    chk(!ack, "R8 acknowledge lasts one cycle", 64'(ack), 64'd0);
    if (!hold) repeat (3 * per_of(cfg_div)) @(negedge clk);
    t0 = -1;
    for (int i = st; i < lg_n; i++) begin
      if (lg[i & 1023][30] || lg[i & 1023][29]) begin t0 = i; break; end
    end
    chk(t0 >= 0, "R8 bus activity found", 64'(t0), 64'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !bus_dq_oe && !bus_clk && !ack, "R1 in reset",
        64'({bus_rd, bus_wr, bus_dq_oe, bus_clk, ack}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_rd && !bus_wr && !bus_dq_oe && !ack, "R1 after reset",
        64'({bus_rd, bus_wr, bus_dq_oe, ack}), 64'd0);
  endtask

  task automatic t_divider(input logic [7:0] d);
    int p, h;
    @(negedge clk);
    cfg_div = d;
    repeat (20) @(negedge clk);
    while (!(bus_clk && !pbc)) @(negedge clk);  // observe a rise
    p = 0; h = 0;
    do begin
      if (bus_clk) h++;
      @(negedge clk);
      p++;
    end while (!(bus_clk && !pbc));
    chk(p == per_of(d), "R2 bus clock period", 64'(p), 64'(per_of(d)));
    chk(h == per_of(d) / 2, "R2 bus clock high time", 64'(h), 64'(per_of(d) / 2));
  endtask

  task automatic t_read16(input logic [11:0] a);
    access(1'b0, 1'b0, a, 32'h0, 1'b0);
    chk_ent(t0,     1, 0, 0, a, 16'h0, "R3 read address phase");
    chk_ent(t0 + 1, 0, 0, 0, a, 16'h0, "R3 read data phase");
    chk_idle(t0 + 2, "R7 idle after read");
    chk(got == {16'h0, pv(a)}, "R3 read data", 64'(got), 64'({16'h0, pv(a)}));
  endtask

  task automatic t_read32_wrap;
    access(1'b0, 1'b1, 12'hFFF, 32'h0, 1'b0);
    chk_ent(t0,     1, 0, 0, 12'hFFF, 16'h0, "R4 low half address");
    chk_ent(t0 + 1, 0, 0, 0, 12'hFFF, 16'h0, "R4 low half data");
    chk_ent(t0 + 2, 1, 0, 0, 12'h000, 16'h0, "R4 high half wraps address");
    chk_ent(t0 + 3, 0, 0, 0, 12'h000, 16'h0, "R4 high half data");
    chk_idle(t0 + 4, "R4 idle after burst");
    chk(got == {pv(12'h000), pv(12'hFFF)}, "R4 read32 data", 64'(got),
        64'({pv(12'h000), pv(12'hFFF)}));
  endtask

  task automatic t_write2(input logic wide);
    @(negedge clk); cfg_wr2 = 1'b1;
    access(1'b1, wide, 12'h123, 32'hBEEF_1234, 1'b0);
    chk_ent(t0,     0, 1, 0, 12'h123, 16'h0,    "R5 write address phase");
    chk_ent(t0 + 1, 0, 0, 1, 12'h123, 16'h1234, "R5 write data phase");
    if (wide) begin
      chk_ent(t0 + 2, 0, 1, 0, 12'h124, 16'h0,    "R4 write high address phase");
      chk_ent(t0 + 3, 0, 0, 1, 12'h124, 16'hBEEF, "R4 write high data phase");
      chk_idle(t0 + 4, "R7 release after write");
    end else begin
      chk_idle(t0 + 2, "R7 release after write");
    end
  endtask

  task automatic t_write1(input logic wide);
    @(negedge clk); cfg_wr2 = 1'b0;
    access(1'b1, wide, 12'h7F0, 32'hA55A_0FF0, 1'b0);
    chk_ent(t0, 0, 1, 1, 12'h7F0, 16'h0FF0, "R6 single clock write");
    if (wide) begin
      chk_ent(t0 + 1, 0, 1, 1, 12'h7F1, 16'hA55A, "R6 single clock write high half");
      chk_idle(t0 + 2, "R6 release after write");
    end else begin
      chk_idle(t0 + 1, "R6 release after write");
    end
    @(negedge clk); cfg_wr2 = 1'b1;
  endtask

  task automatic t_burst8;
    int st, pulses, cyc;
    st = lg_n;
    for (int k = 0; k < 8; k++) access(1'b0, 1'b1, 12'(16 * k), 32'h0, 1'b0);
    pulses = 0;
    for (int i = st; i < lg_n; i++) if (lg[i & 1023][30]) pulses++;
    chk(pulses == 16, "R4 eight wide reads give sixteen strobes", 64'(pulses), 64'd16);
    cyc = 0;
    for (int i = t0; i < lg_n; i++) if (lg[i & 1023][30] || cyc > 0) cyc++;
    chk(lg[(t0 + 3) & 1023][30] == 1'b0 && lg[(t0 + 2) & 1023][30] == 1'b1,
        "R4 strobe low between halves", 64'(lg[(t0 + 2) & 1023][30]), 64'd1);
  endtask

  task automatic t_held;
    // request stays high across its acknowledge: next cycle must be idle, then restart
    access(1'b0, 1'b0, 12'h055, 32'h0, 1'b1);
    chk_ent(t0, 1, 0, 0, 12'h055, 16'h0, "R8 first read");
    repeat (4 * per_of(cfg_div)) @(negedge clk);
    req = 1'b0;
    repeat (4 * per_of(cfg_div)) @(negedge clk);
    chk_idle(t0 + 2, "R8 idle clock before restart");
    chk_ent(t0 + 3, 1, 0, 0, 12'h055, 16'h0, "R8 restart after idle clock");
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_divider(8'd1);
    t_divider(8'd0);
    t_divider(8'd3);
    t_read16(12'h3A7);
    t_divider(8'd1);
    t_read16(12'h001);
    t_read32_wrap();
    t_write2(1'b0);
    t_write2(1'b1);
    t_write1(1'b0);
    t_write1(1'b1);
    t_burst8();
    t_held();
    chk(both_seen == 0, "R9 strobes exclusive", 64'(both_seen), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule